// File: doc/BRIEF.md
# Infrared Pulse-Duration Capture Receiver

This block watches a single infrared input line and turns it into a stream of run-length records. The line is first resynchronised to the system clock. A glitch filter then removes pulses that are shorter than a programmable minimum. Once capture is running, the block counts how many sampling ticks the filtered line stays at one level. When that level changes, it emits a one-cycle record that carries the finished level and its length. Records go to an external storage FIFO, which is not part of this block. The block does no carrier demodulation and no protocol decoding.

Capture is armed by the receiver enable. It then starts in one of two ways: on a software start strobe (manual mode), or on a selected edge of the filtered line (automatic mode). A duration-threshold flag rises when the selected level has lasted at least a programmed number of ticks. Software uses this flag as its end-of-frame cue and then turns the receiver off. Turning the receiver off flushes the run that is still open as a final record. When a run would exceed the counter range, the counter saturates and a sticky overflow flag is set.

Top module: `ir_capture_rx`

## Requirements
- R1: Each record holds the level of the finished run in the top bit (bit 31 at the default 32-bit width) and the run length in sampling ticks in the bits below it. `rec_valid_o` is high for exactly one cycle per record. A record is produced one cycle after the filtered line is seen to change.
- R2: With `start_mode_i` = 0 (manual), capture begins only on a `sw_start_i` pulse. Edges on the line do not start capture. The first run counts from the cycle of the pulse.
- R3: With `start_mode_i` = 1 (automatic), capture begins on the edge chosen by `trig_sel_i`: 0 = falling, 1 = rising, 2 = either. Edges of the other direction and `sw_start_i` are ignored while waiting.
- R4: With filter code c, a new level is accepted only after it has been stable for (c+1)*FILT_STEP system clocks. Shorter pulses are ignored and do not split the run they fall in.
- R5: `thr_level_i` selects the watched level (0 = low, 1 = high). `thr_irq_o` rises when a run of the watched level reaches a count of at least `thr_value_i`. Runs of the other level never raise it.
- R6: Once raised, `thr_irq_o` stays high through later level changes while capture continues. It drops only when the receiver is disabled.
- R7: At the all-ones value the run counter saturates. `ovf_o` is then set and held until `ovf_clr_i` is pulsed. A clear takes priority over a new overflow.
- R8: Disabling the receiver during capture emits one record for the open run and returns the block to idle. Disabling it when idle emits nothing.
- R9: Run lengths are counted in sampling ticks. A tick occurs every `tick_div_i`+1 system clocks while the receiver is enabled.
- R10: Under reset, `rec_valid_o`, `rec_data_o`, `thr_irq_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receiver enable; low flushes the open run and idles |
| start_mode_i | input | 1 | 0 = start on software strobe, 1 = start on line edge |
| trig_sel_i | input | 2 | Edge used in automatic mode: 0 fall, 1 rise, 2 any |
| sw_start_i | input | 1 | Software start strobe (manual mode) |
| filt_code_i | input | FCODE_W | Glitch filter setting |
| tick_div_i | input | TICK_W | Sampling tick divider, tick every value+1 clocks |
| thr_level_i | input | 1 | Level watched by the threshold: 0 low, 1 high |
| thr_value_i | input | REC_W-1 | Threshold run length in ticks |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ir_i | input | 1 | Asynchronous infrared line |
| rec_valid_o | output | 1 | One-cycle record strobe |
| rec_data_o | output | REC_W | Record: level in top bit, run length below |
| thr_irq_o | output | 1 | Duration-threshold flag |
| ovf_o | output | 1 | Sticky counter-overflow flag |

## Verification
An input change reaches the filtered level SYNC_STAGES+N-1 clocks after the edge that samples it, where N is the filter length. The record follows on the next edge. The bench therefore drives all inputs on falling edges and predicts every count from those fixed latencies. The manual-start run expects K+N+2 for a change driven K clocks after the strobe, and the flushed run expects 10-N-2 for a disable issued 10 clocks after the last change. The threshold flag is due exactly N+T+3 edges after the change that opens the watched run. The bench samples it one edge before that and on that edge, to catch both an early and a late flag.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

   typedef enum logic [1:0] {
      TRIG_FALL = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_ANY  = 2'd2,
      TRIG_NONE = 2'd3
   } trig_e;

   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_RUN  = 1'b1
   } cap_state_e;

   // true when the transition prev -> cur matches the selected trigger
   function automatic logic edge_hit(input trig_e sel, input logic prev, input logic cur);
      logic rise, fall;
      rise = !prev && cur;
      fall = prev && !cur;
      case (sel)
         TRIG_FALL: edge_hit = fall;
         TRIG_RISE: edge_hit = rise;
         TRIG_ANY:  edge_hit = rise || fall;
         default:   edge_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ir_sync_filter.sv
module ir_sync_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FCODE_W     = 3,
   parameter int   FILT_STEP   = 2,
   parameter logic IDLE_LVL    = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               raw_i,
   input  logic [FCODE_W-1:0] code_i,
   output logic               level_o
);
   localparam int MAX_LEN = (1 << FCODE_W) * FILT_STEP;
   localparam int STAB_W  = $clog2(MAX_LEN) + 1;

   logic              synced;
   logic [STAB_W-1:0] stab_q;
   logic [STAB_W-1:0] need;
   logic              lvl_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         logic s_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) s_q <= IDLE_LVL;
            else         s_q <= raw_i;
         end
         assign synced = s_q;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= {SYNC_STAGES{IDLE_LVL}};
            else         chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
         end
         assign synced = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // required stable length minus one: (code+1)*step - 1
   assign need = STAB_W'((32'(code_i) + 32'd1) * 32'(FILT_STEP) - 32'd1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q  <= IDLE_LVL;
         stab_q <= '0;
      end else if (synced == lvl_q) begin
         stab_q <= '0;
      end else if (stab_q >= need) begin
         lvl_q  <= synced;
         stab_q <= '0;
      end else begin
         stab_q <= stab_q + 1'b1;
      end
   end

   assign level_o = lvl_q;

endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
   parameter int TICK_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [TICK_W-1:0] div_i,
   output logic              tick_o
);
   logic [TICK_W-1:0] cnt_q;

   assign tick_o = (cnt_q == div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (!run_i || tick_o)  cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/ir_start_ctrl.sv
module ir_start_ctrl
   import ir_cap_pkg::*;
#(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       lvl_i,
   input  logic       mode_i,
   input  logic [1:0] trig_i,
   input  logic       sw_start_i,
   output logic       go_o
);
   logic lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= IDLE_LVL;
      else         lvl_q <= lvl_i;
   end

   assign go_o = mode_i ? edge_hit(trig_e'(trig_i), lvl_q, lvl_i) : sw_start_i;

endmodule

// File: rtl/ir_run_counter.sv
module ir_run_counter
   import ir_cap_pkg::*;
#(
   parameter int CNT_W = 31
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             go_i,
   input  logic             tick_i,
   input  logic             lvl_i,
   input  logic             thr_lvl_i,
   input  logic [CNT_W-1:0] thr_val_i,
   input  logic             ovf_clr_i,
   output logic             rec_valid_o,
   output logic             rec_lvl_o,
   output logic [CNT_W-1:0] rec_cnt_o,
   output logic             thr_o,
   output logic             ovf_o,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cap_state_e       state_q;
   logic             run_lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_set;

   assign ovf_set = (state_q == CAP_RUN) && en_i && tick_i &&
                    (lvl_i == run_lvl_q) && (&cnt_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= CAP_IDLE;
         run_lvl_q   <= 1'b0;
         cnt_q       <= '0;
         rec_valid_o <= 1'b0;
         rec_lvl_o   <= 1'b0;
         rec_cnt_o   <= '0;
         thr_o       <= 1'b0;
      end else begin
         rec_valid_o <= 1'b0;
         if (!en_i) thr_o <= 1'b0;
         case (state_q)
            CAP_IDLE: begin
               if (en_i && go_i) begin
                  state_q   <= CAP_RUN;
                  run_lvl_q <= lvl_i;
                  cnt_q     <= tick_i ? ONE : '0;
               end
            end
            CAP_RUN: begin
               if (!en_i) begin
                  // flush the open run
                  rec_valid_o <= 1'b1;
                  rec_lvl_o   <= run_lvl_q;
                  rec_cnt_o   <= cnt_q;
                  state_q     <= CAP_IDLE;
               end else begin
                  if (run_lvl_q == thr_lvl_i && cnt_q >= thr_val_i) thr_o <= 1'b1;
                  if (tick_i) begin
                     if (lvl_i != run_lvl_q) begin
                        rec_valid_o <= 1'b1;
                        rec_lvl_o   <= run_lvl_q;
                        rec_cnt_o   <= cnt_q;
                        run_lvl_q   <= lvl_i;
                        cnt_q       <= ONE;
                     end else if (!(&cnt_q)) begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
            end
            default: state_q <= CAP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ovf_o <= 1'b0;
      else if (ovf_clr_i) ovf_o <= 1'b0;
      else if (ovf_set)   ovf_o <= 1'b1;
   end

   assign run_o = (state_q == CAP_RUN);
   assign cnt_o = cnt_q;

endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx #(
   parameter int   REC_W       = 32,
   parameter int   FCODE_W     = 3,
   parameter int   FILT_STEP   = 2,
   parameter int   SYNC_STAGES = 2,
   parameter int   TICK_W      = 16,
   parameter logic IDLE_LVL    = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rx_en_i,
   input  logic               start_mode_i,
   input  logic [1:0]         trig_sel_i,
   input  logic               sw_start_i,
   input  logic [FCODE_W-1:0] filt_code_i,
   input  logic [TICK_W-1:0]  tick_div_i,
   input  logic               thr_level_i,
   input  logic [REC_W-2:0]   thr_value_i,
   input  logic               ovf_clr_i,
   input  logic               ir_i,
   output logic               rec_valid_o,
   output logic [REC_W-1:0]   rec_data_o,
   output logic               thr_irq_o,
   output logic               ovf_o
);
   localparam int CNT_W = REC_W - 1;

   generate
      if (REC_W < 8 || REC_W > 64) begin : g_bad_rec_w
         $error("ir_capture_rx: REC_W must lie in 8..64");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("ir_capture_rx: SYNC_STAGES must be at least 1");
      end
      if (FILT_STEP < 1 || FCODE_W < 1) begin : g_bad_filt
         $error("ir_capture_rx: filter parameters must be positive");
      end
      if (TICK_W < 1) begin : g_bad_tick
         $error("ir_capture_rx: TICK_W must be positive");
      end
   endgenerate

   logic             lvl_w;
   logic             tick_w;
   logic             go_w;
   logic             run_w;
   logic [CNT_W-1:0] cnt_w;
   logic             rec_lvl_w;
   logic [CNT_W-1:0] rec_cnt_w;

   ir_sync_filter #(
      .SYNC_STAGES(SYNC_STAGES), .FCODE_W(FCODE_W),
      .FILT_STEP(FILT_STEP), .IDLE_LVL(IDLE_LVL)
   ) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ir_i),
      .code_i(filt_code_i), .level_o(lvl_w)
   );

   ir_tick_gen #(.TICK_W(TICK_W)) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(rx_en_i),
      .div_i(tick_div_i), .tick_o(tick_w)
   );

   ir_start_ctrl #(.IDLE_LVL(IDLE_LVL)) u_start (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_w),
      .mode_i(start_mode_i), .trig_i(trig_sel_i),
      .sw_start_i(sw_start_i), .go_o(go_w)
   );

   ir_run_counter #(.CNT_W(CNT_W)) u_run (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .go_i(go_w),
      .tick_i(tick_w), .lvl_i(lvl_w), .thr_lvl_i(thr_level_i),
      .thr_val_i(thr_value_i), .ovf_clr_i(ovf_clr_i),
      .rec_valid_o(rec_valid_o), .rec_lvl_o(rec_lvl_w), .rec_cnt_o(rec_cnt_w),
      .thr_o(thr_irq_o), .ovf_o(ovf_o), .run_o(run_w), .cnt_o(cnt_w)
   );

   assign rec_data_o = {rec_lvl_w, rec_cnt_w};

endmodule

// File: rtl/ir_capture_rx_chk.sv
module ir_capture_rx_chk #(
   parameter int CNT_W = 31
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rx_en_i,
   input logic             ovf_clr_i,
   input logic             rec_valid_o,
   input logic             thr_irq_o,
   input logic             ovf_o,
   input logic             run_i,
   input logic [CNT_W-1:0] cnt_i
);
   // R8: a record only follows a cycle in which capture was running
   a_r8_rec_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_valid_o |-> $past(run_i));

   // R6: disabling the receiver drops the threshold flag
   a_r6_thr_drops_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rx_en_i |=> !thr_irq_o);

   // R5: the threshold flag can only rise out of an active capture
   a_r5_thr_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(thr_irq_o) |-> $past(run_i));

   // R7: overflow flag is sticky
   a_r7_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !ovf_clr_i) |=> ovf_o);

   // R7: clear wins
   a_r7_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_clr_i |=> !ovf_o);

   // R7: a saturated count never wraps inside the same run
   a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && (&cnt_i)) |=> ((&cnt_i) || rec_valid_o || !run_i));

endmodule

bind ir_capture_rx ir_capture_rx_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .ovf_clr_i(ovf_clr_i),
   .rec_valid_o(rec_valid_o), .thr_irq_o(thr_irq_o), .ovf_o(ovf_o),
   .run_i(run_w), .cnt_i(cnt_w)
);

// File: tb/ir_capture_rx_tb.sv
`timescale 1ns/1ps
module ir_capture_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        start_mode = 1'b1;
   logic [1:0]  trig_sel = 2'd2;
   logic        sw_start = 1'b0;
   logic [2:0]  filt_code = 3'd0;
   logic [15:0] tick_div = 16'd0;
   logic        thr_level = 1'b0;
   logic [30:0] thr_value = 31'h7FFFFFFF;
   logic        ovf_clr = 1'b0;
   logic        ir = 1'b1;

   logic        rec_valid, thr_irq, ovf;
   logic [31:0] rec_data;
   logic        rec_valid2, thr_irq2, ovf2;
   logic [11:0] rec_data2;

   int tests = 0;
   int fails = 0;
   int rn = 0;
   logic [31:0] recs [0:63];
   logic [11:0] last2 = '0;

   always #10 clk = ~clk;   // 50 MHz

   ir_capture_rx dut_i (
      .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .start_mode_i(start_mode),
      .trig_sel_i(trig_sel), .sw_start_i(sw_start), .filt_code_i(filt_code),
      .tick_div_i(tick_div), .thr_level_i(thr_level), .thr_value_i(thr_value),
      .ovf_clr_i(ovf_clr), .ir_i(ir), .rec_valid_o(rec_valid),
      .rec_data_o(rec_data), .thr_irq_o(thr_irq), .ovf_o(ovf)
   );

   // narrow instance so saturation is reachable
   ir_capture_rx #(.REC_W(12)) dut_narrow_i (
      .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .start_mode_i(start_mode),
      .trig_sel_i(trig_sel), .sw_start_i(sw_start), .filt_code_i(filt_code),
      .tick_div_i(tick_div), .thr_level_i(thr_level), .thr_value_i(thr_value[10:0]),
      .ovf_clr_i(ovf_clr), .ir_i(ir), .rec_valid_o(rec_valid2),
      .rec_data_o(rec_data2), .thr_irq_o(thr_irq2), .ovf_o(ovf2)
   );

   always @(negedge clk) begin
      if (rec_valid && rn < 64) begin
         recs[rn] = rec_data;
         rn = rn + 1;
      end
      if (rec_valid2) last2 = rec_data2;
   end

   // {trig, level before, d0, d1, d2}
   localparam logic [50:0] VEC [0:4] = '{
      {2'd0, 1'b1, 16'd30, 16'd20, 16'd25},
      {2'd1, 1'b1, 16'd15, 16'd40, 16'd22},
      {2'd1, 1'b0, 16'd18, 16'd26, 16'd14},
      {2'd2, 1'b0, 16'd12, 16'd33, 16'd17},
      {2'd0, 1'b0, 16'd21, 16'd19, 16'd28}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic l, input int c);
      return {l, 31'(c)};
   endfunction

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic arm(input logic mode, input logic [1:0] trig, input logic lb,
                      input logic [2:0] code, input logic [15:0] div);
      rx_en = 1'b0; ir = lb; start_mode = mode; trig_sel = trig;
      filt_code = code; tick_div = div;
      wait_n(12);
   endtask

   task automatic run_row(input logic [50:0] v);
      logic [1:0] trig;
      logic lb, match;
      int d0, d1, d2, base, n;
      trig = v[50:49]; lb = v[48];
      d0 = int'(v[47:32]); d1 = int'(v[31:16]); d2 = int'(v[15:0]);
      arm(1'b1, trig, lb, 3'd0, 16'd0);
      base = rn;
      rx_en = 1'b1; wait_n(5);
      ir = ~lb; wait_n(d0);
      ir = lb;  wait_n(d1);
      ir = ~lb; wait_n(d2);
      ir = lb;  wait_n(10);
      rx_en = 1'b0; wait_n(5);
      match = (trig == 2'd2) || (trig == 2'd1 && !lb) || (trig == 2'd0 && lb);
      n = match ? 4 : 3;
      chk("R3 record count for trigger row", 32'(rn - base), 32'(n));
      if (match) begin
         chk("R1 first run record", recs[base], mk(~lb, d0));
         base++;
      end
      chk("R1 middle run record", recs[base], mk(lb, d1));
      chk("R1 last closed run record", recs[base+1], mk(~lb, d2));
      chk("R8 flushed open run on disable", recs[base+2], mk(lb, 6));
   endtask

   initial begin
      int base;
      // R10 reset state
      wait_n(3);
      chk("R10 rec_valid in reset", 32'(rec_valid), 32'd0);
      chk("R10 rec_data in reset", rec_data, 32'd0);
      chk("R10 thr_irq in reset", 32'(thr_irq), 32'd0);
      chk("R10 ovf in reset", 32'(ovf), 32'd0);
      rst_n = 1'b1;
      wait_n(4);

      // table of automatic-trigger scenarios (R1, R3, R8)
      for (int i = 0; i < 5; i++) run_row(VEC[i]);

      // R2 manual: edges alone do nothing, strobe starts capture
      arm(1'b0, 2'd2, 1'b1, 3'd0, 16'd0);
      base = rn;
      rx_en = 1'b1; wait_n(3);
      ir = 1'b0; wait_n(20);
      ir = 1'b1; wait_n(10);
      ir = 1'b0; wait_n(20);
      chk("R2 no record before start strobe", 32'(rn - base), 32'd0);
      sw_start = 1'b1; @(negedge clk);
      sw_start = 1'b0; wait_n(9);
      ir = 1'b1; wait_n(20);
      rx_en = 1'b0; wait_n(5);
      chk("R2 record count after strobe", 32'(rn - base), 32'd2);
      chk("R2 first run counted from strobe", recs[base], mk(1'b0, 14));

      // R3 software strobe ignored in automatic mode; R8 idle disable is silent
      arm(1'b1, 2'd0, 1'b1, 3'd0, 16'd0);
      base = rn;
      rx_en = 1'b1; wait_n(3);
      sw_start = 1'b1; @(negedge clk);
      sw_start = 1'b0; wait_n(20);
      rx_en = 1'b0; wait_n(5);
      chk("R3 strobe ignored in auto mode", 32'(rn - base), 32'd0);

      // R4 glitch filter, code 1 -> 4 clocks
      arm(1'b1, 2'd2, 1'b1, 3'd1, 16'd0);
      base = rn;
      rx_en = 1'b1; wait_n(5);
      ir = 1'b0; wait_n(30);
      ir = 1'b1; wait_n(3);
      ir = 1'b0; wait_n(30);
      ir = 1'b1; wait_n(4);
      ir = 1'b0; wait_n(20);
      ir = 1'b1; wait_n(20);
      rx_en = 1'b0; wait_n(5);
      chk("R4 record count with glitches", 32'(rn - base), 32'd4);
      chk("R4 short pulse absorbed into run", recs[base], mk(1'b0, 63));
      chk("R4 pulse at filter length passes", recs[base+1], mk(1'b1, 4));
      chk("R4 run after accepted pulse", recs[base+2], mk(1'b0, 20));

      // R5/R6 threshold on low level, T = 50
      thr_level = 1'b0; thr_value = 31'd50;
      arm(1'b1, 2'd2, 1'b1, 3'd0, 16'd0);
      rx_en = 1'b1; wait_n(5);
      ir = 1'b0; wait_n(54);
      chk("R5 threshold flag one edge early", 32'(thr_irq), 32'd0);
      wait_n(1);
      chk("R5 threshold flag on time", 32'(thr_irq), 32'd1);
      ir = 1'b1; wait_n(100);
      chk("R6 flag held across level change", 32'(thr_irq), 32'd1);
      rx_en = 1'b0; wait_n(2);
      chk("R6 flag cleared by disable", 32'(thr_irq), 32'd0);

      // R5 other level never raises the flag
      thr_level = 1'b1;
      arm(1'b1, 2'd2, 1'b1, 3'd0, 16'd0);
      rx_en = 1'b1; wait_n(5);
      ir = 1'b0; wait_n(100);
      chk("R5 low run with high watched", 32'(thr_irq), 32'd0);
      ir = 1'b1; wait_n(80);
      chk("R5 high run reaches threshold", 32'(thr_irq), 32'd1);
      rx_en = 1'b0; wait_n(5);
      thr_value = 31'h7FFFFFFF;

      // R9 sampling divider: tick every 4 clocks
      arm(1'b1, 2'd2, 1'b1, 3'd0, 16'd3);
      base = rn;
      rx_en = 1'b1; wait_n(5);
      ir = 1'b0; wait_n(40);
      ir = 1'b1; wait_n(24);
      ir = 1'b0; wait_n(20);
      rx_en = 1'b0; wait_n(5);
      chk("R9 low run in ticks", recs[base], mk(1'b0, 10));
      chk("R9 high run in ticks", recs[base+1], mk(1'b1, 6));

      // R7 saturation and sticky overflow on the narrow instance
      arm(1'b1, 2'd2, 1'b1, 3'd0, 16'd0);
      rx_en = 1'b1; wait_n(5);
      ir = 1'b0; wait_n(2000);
      chk("R7 no overflow below range", 32'(ovf2), 32'd0);
      wait_n(100);
      chk("R7 overflow set", 32'(ovf2), 32'd1);
      chk("R7 wide counter not overflowed", 32'(ovf), 32'd0);
      ir = 1'b1; wait_n(10);
      chk("R7 saturated record", 32'(last2), 32'h7FF);
      wait_n(20);
      chk("R7 overflow sticky", 32'(ovf2), 32'd1);
      ovf_clr = 1'b1; @(negedge clk);
      ovf_clr = 1'b0; wait_n(2);
      chk("R7 overflow cleared", 32'(ovf2), 32'd0);
      rx_en = 1'b0; wait_n(5);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule